// File: doc/BRIEF.md
# Interrupt Routing and Priority Controller

This block sits between a set of peripheral event sources and the interrupt input of a processor core. Each source has a raw status bit and an enable bit. Their AND, the masked status, is steered by a programmable map register onto one of 32 core interrupt lines. Lines 26 to 31 are parking lines that never interrupt, so a source that is not in use can be sent there. Each line has a priority and a trigger type (edge or level) fixed by parameter. A line-enable mask and a running level field then filter the lines. The highest eligible line is taken.

On a take the block issues a one-cycle strobe together with the winning line, its priority level and a vector address. The vector is a programmable base plus an offset chosen by class: level-1, higher level, or non-maskable. Taking a maskable line raises the level field to the winner's priority. Software lowers the field again through the register port when the handler is done. One line is non-maskable. It ignores both the enable mask and the level field.

Register port (word addresses): 0x00 line enable mask, 0x01 pending (read; write 1 to clear edge bits), 0x02 level field (bits 2:0), 0x03 vector base, 0x04 source raw (read only), 0x05 source enable, 0x06 source masked (read only), 0x10+s map register of source s (bits 4:0).

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset the line enable mask, level field, pending register, source enables and take strobe are all zero, and every map register holds 26 (a parking line).
- R2: Register 0x06 reads raw AND enable per source, and a source drives its mapped line only through this masked bit.
- R3: The low 5 bits of a source's map register select the line it drives, a write takes effect from the next cycle, and sources mapped to the same line are ORed.
- R4: Lines 26 to 31 never show pending and are never taken, whatever is mapped onto them.
- R5: Level-type lines (even indices, by default) show pending exactly while their routed input is high. Edge-type lines (odd indices) set pending on a rising input and hold it until a write of 1 to that bit of register 0x01.
- R6: A maskable line whose bit in the enable mask is 0 is never taken, though its pending bit stays visible.
- R7: A maskable line is taken only if its priority is strictly above the level field, and on a take the field becomes the winner's priority.
- R8: Among eligible lines the highest priority wins, with ties going to the lowest line index. Default priorities are: lines 0-7 level 1, 8-15 level 2, 16-19 level 3, 20-23 level 4, 24 level 5, 26-31 level 1.
- R9: The vector is the base plus 0x100 for a level-1 winner, plus 0x180 for a higher-level winner, and plus 0x2C0 for the non-maskable line. take_level reports the winner's priority, which is 7 for the non-maskable line.
- R10: Line 25 is non-maskable and edge-type. It is taken regardless of the enable mask and the level field, its pending bit clears on the take, and the level field is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_raw | input | NUM_SRC | Raw event status of each peripheral source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| take | output | 1 | One-cycle strobe: an interrupt is taken |
| take_line | output | 5 | Line index of the taken interrupt |
| take_level | output | 3 | Priority level of the taken interrupt |
| take_vec | output | 32 | Vector address of the taken interrupt |

## Verification
Routing is tried with a single source on a level line, two sources merged onto one line, and a source sent to a parking line. These cases separate the decode of the map field, the OR merge and the parking suppression. Arbitration is driven with three lines asserted together. Two of them share a priority, so releasing them one at a time tells priority order apart from index tie-breaking and from the class-based vector offset. The same edge line is raised with its enable bit clear and then set, and under several level-field values, which separates the enable mask from the threshold. The non-maskable line is raised with every filter closed to show that it bypasses them.

// File: rtl/irq_route_pkg.sv
// Shared constants and default line configuration for the interrupt router.
// Assumes 32 core lines, selected by a 5-bit map field, and 3-bit priority levels.
package irq_route_pkg;
    localparam int LINES     = 32;
    localparam int LINE_W    = 5;
    localparam int LVL_W     = 3;
    localparam int NMI_LEVEL = 7;

    // Default build-time priority for each line, packed LVL_W bits per line
    function automatic logic [LINES*LVL_W-1:0] default_prio();
        logic [LINES*LVL_W-1:0] p;
        logic [LVL_W-1:0]       v;
        p = '0;
        for (int j = 0; j < LINES; j++) begin
            if (j < 8)        v = 3'd1;
            else if (j < 16)  v = 3'd2;
            else if (j < 20)  v = 3'd3;
            else if (j < 24)  v = 3'd4;
            else if (j == 24) v = 3'd5;
            else if (j == 25) v = 3'(NMI_LEVEL);
            else              v = 3'd1;
            p[j*LVL_W +: LVL_W] = v;
        end
        return p;
    endfunction
endpackage

// File: rtl/irq_src_matrix.sv
// Source-to-line routing matrix: each masked source bit is ORed onto the
// line its map field selects; parking lines are forced low.
// Assumes map fields are already registered by the caller.
module irq_src_matrix #(
    parameter int                 NUM_SRC   = 6,
    parameter int                 LINES     = 32,
    parameter int                 LINE_W    = 5,
    parameter logic [LINES-1:0]   PARK_MASK = '0
) (
    input  logic [NUM_SRC-1:0]             src_masked,
    input  logic [NUM_SRC-1:0][LINE_W-1:0] map_sel,
    output logic [LINES-1:0]               line_in
);
    // OR every masked source onto its selected line, then drop parked lines
    always_comb begin
        line_in = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            line_in[map_sel[s]] = line_in[map_sel[s]] | src_masked[s];
        end
        line_in = line_in & ~PARK_MASK;
    end
endmodule

// File: rtl/irq_line_pending.sv
// Per-line pending capture: edge lines latch a rising input until cleared,
// level lines follow their input. Trigger type per line fixed by LINE_EDGE.
// Assumes clr_mask is a one-cycle pulse; a set in the same cycle wins.
module irq_line_pending #(
    parameter int               LINES     = 32,
    parameter logic [LINES-1:0] LINE_EDGE = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] line_in,
    input  logic [LINES-1:0] clr_mask,
    output logic [LINES-1:0] pending
);
    for (genvar j = 0; j < LINES; j++) begin : g_line
        if (LINE_EDGE[j]) begin : g_edge
            logic prev_q;
            logic pend_q;
            // Track previous input and latch rising edges until cleared
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    prev_q <= 1'b0;
                    pend_q <= 1'b0;
                end else begin
                    prev_q <= line_in[j];
                    pend_q <= (pend_q & ~clr_mask[j]) | (line_in[j] & ~prev_q);
                end
            end
            assign pending[j] = pend_q;
        end else begin : g_level
            assign pending[j] = line_in[j];
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
// Combinational winner selection: non-maskable line first, otherwise the
// highest priority enabled line above the current level, lowest index on ties.
// Assumes priorities of maskable lines are at least 1.
module irq_arbiter #(
    parameter int                     LINES     = 32,
    parameter int                     LINE_W    = 5,
    parameter int                     LVL_W     = 3,
    parameter int                     NMI_LINE  = 25,
    parameter int                     NMI_LEVEL = 7,
    parameter logic [LINES*LVL_W-1:0] LINE_PRIO = '0
) (
    input  logic [LINES-1:0]  pending,
    input  logic [LINES-1:0]  line_en,
    input  logic [LVL_W-1:0]  cur_level,
    output logic              win_valid,
    output logic              win_nmi,
    output logic [LINE_W-1:0] win_line,
    output logic [LVL_W-1:0]  win_level
);
    // Scan from the top index down so that >= leaves the lowest index on ties
    always_comb begin
        win_valid = 1'b0;
        win_nmi   = 1'b0;
        win_line  = '0;
        win_level = '0;
        for (int j = LINES - 1; j >= 0; j--) begin
            if (j != NMI_LINE && pending[j] && line_en[j]
                && LINE_PRIO[j*LVL_W +: LVL_W] > cur_level
                && (!win_valid || LINE_PRIO[j*LVL_W +: LVL_W] >= win_level)) begin
                win_valid = 1'b1;
                win_line  = LINE_W'(j);
                win_level = LINE_PRIO[j*LVL_W +: LVL_W];
            end
        end
        if (pending[NMI_LINE]) begin
            win_valid = 1'b1;
            win_nmi   = 1'b1;
            win_line  = LINE_W'(NMI_LINE);
            win_level = LVL_W'(NMI_LEVEL);
        end
    end
endmodule

// File: rtl/irq_route_ctrl.sv
// Top of the interrupt router: register port, source status, routing matrix,
// pending capture, arbitration and the registered take/vector outputs.
// Assumes NUM_SRC <= 16 (map registers at word addresses 0x10..0x1F).
module irq_route_ctrl
    import irq_route_pkg::*;
#(
    parameter int                     NUM_SRC   = 6,
    parameter int                     NMI_LINE  = 25,
    parameter logic [LINES-1:0]       PARK_MASK = 32'hFC00_0000,
    parameter logic [LINES-1:0]       LINE_EDGE = 32'hAAAA_AAAA,
    parameter logic [LINES*LVL_W-1:0] LINE_PRIO = default_prio(),
    parameter logic [LINE_W-1:0]      PARK_LINE = 5'd26,
    parameter logic [31:0]            OFF_L1    = 32'h0000_0100,
    parameter logic [31:0]            OFF_HI    = 32'h0000_0180,
    parameter logic [31:0]            OFF_NMI   = 32'h0000_02C0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_raw,
    input  logic               wr_en,
    input  logic [7:0]         wr_addr,
    input  logic [31:0]        wr_data,
    input  logic [7:0]         rd_addr,
    output logic [31:0]        rd_data,
    output logic               take,
    output logic [4:0]         take_line,
    output logic [2:0]         take_level,
    output logic [31:0]        take_vec
);
    localparam logic [7:0] A_EN     = 8'h00;
    localparam logic [7:0] A_PEND   = 8'h01;
    localparam logic [7:0] A_LEVEL  = 8'h02;
    localparam logic [7:0] A_BASE   = 8'h03;
    localparam logic [7:0] A_RAW    = 8'h04;
    localparam logic [7:0] A_SRCEN  = 8'h05;
    localparam logic [7:0] A_MASKED = 8'h06;
    localparam logic [7:0] A_MAP    = 8'h10;

    logic [LINES-1:0]               line_en;
    logic [LVL_W-1:0]               cur_level;
    logic [31:0]                    vec_base;
    logic [NUM_SRC-1:0]             src_en;
    logic [NUM_SRC-1:0][LINE_W-1:0] map_sel;
    logic [NUM_SRC-1:0]             src_masked;
    logic [LINES-1:0]               line_in;
    logic [LINES-1:0]               pending;
    logic [LINES-1:0]               clr_mask;
    logic                           win_valid;
    logic                           win_nmi;
    logic [LINE_W-1:0]              win_line;
    logic [LVL_W-1:0]               win_level;

    assign src_masked = src_raw & src_en;

    // Write-1-to-clear from software plus automatic clear of a taken NMI
    always_comb begin
        clr_mask = '0;
        if (wr_en && wr_addr == A_PEND) clr_mask = wr_data;
        if (win_nmi) clr_mask[NMI_LINE] = 1'b1;
    end

    irq_src_matrix #(
        .NUM_SRC   (NUM_SRC),
        .LINES     (LINES),
        .LINE_W    (LINE_W),
        .PARK_MASK (PARK_MASK)
    ) matrix_i (
        .src_masked (src_masked),
        .map_sel    (map_sel),
        .line_in    (line_in)
    );

    irq_line_pending #(
        .LINES     (LINES),
        .LINE_EDGE (LINE_EDGE)
    ) pend_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_in  (line_in),
        .clr_mask (clr_mask),
        .pending  (pending)
    );

    irq_arbiter #(
        .LINES     (LINES),
        .LINE_W    (LINE_W),
        .LVL_W     (LVL_W),
        .NMI_LINE  (NMI_LINE),
        .NMI_LEVEL (NMI_LEVEL),
        .LINE_PRIO (LINE_PRIO)
    ) arb_i (
        .pending   (pending),
        .line_en   (line_en),
        .cur_level (cur_level),
        .win_valid (win_valid),
        .win_nmi   (win_nmi),
        .win_line  (win_line),
        .win_level (win_level)
    );

    // Software-written configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_en  <= '0;
            vec_base <= '0;
            src_en   <= '0;
            for (int s = 0; s < NUM_SRC; s++) map_sel[s] <= PARK_LINE;
        end else if (wr_en) begin
            if (wr_addr == A_EN)    line_en  <= wr_data;
            if (wr_addr == A_BASE)  vec_base <= wr_data;
            if (wr_addr == A_SRCEN) src_en   <= wr_data[NUM_SRC-1:0];
            for (int s = 0; s < NUM_SRC; s++) begin
                if (wr_addr == A_MAP + 8'(s)) map_sel[s] <= wr_data[LINE_W-1:0];
            end
        end
    end

    // Level field: a maskable take raises it, otherwise software may write it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_level <= '0;
        end else if (win_valid && !win_nmi) begin
            cur_level <= win_level;
        end else if (wr_en && wr_addr == A_LEVEL) begin
            cur_level <= wr_data[LVL_W-1:0];
        end
    end

    // Registered take strobe with line, level and class-based vector
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take       <= 1'b0;
            take_line  <= '0;
            take_level <= '0;
            take_vec   <= '0;
        end else begin
            take <= win_valid;
            if (win_valid) begin
                take_line  <= win_line;
                take_level <= win_level;
                if (win_nmi)              take_vec <= vec_base + OFF_NMI;
                else if (win_level == 3'd1) take_vec <= vec_base + OFF_L1;
                else                      take_vec <= vec_base + OFF_HI;
            end
        end
    end

    // Register read multiplexer
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_EN:     rd_data = line_en;
            A_PEND:   rd_data = pending;
            A_LEVEL:  rd_data = 32'(cur_level);
            A_BASE:   rd_data = vec_base;
            A_RAW:    rd_data = 32'(src_raw);
            A_SRCEN:  rd_data = 32'(src_en);
            A_MASKED: rd_data = 32'(src_masked);
            default: begin
                for (int s = 0; s < NUM_SRC; s++) begin
                    if (rd_addr == A_MAP + 8'(s)) rd_data = 32'(map_sel[s]);
                end
            end
        endcase
    end
endmodule

// File: rtl/irq_route_ctrl_chk.sv
// Property checker for the interrupt router, attached to every instance by bind.
// Assumes it observes the top's internal level field, enable mask and base.
module irq_route_ctrl_chk #(
    parameter int           NMI_LINE  = 25,
    parameter logic [31:0]  PARK_MASK = 32'hFC00_0000,
    parameter logic [31:0]  OFF_L1    = 32'h100
) (
    input logic        clk,
    input logic        rst_n,
    input logic        take,
    input logic [4:0]  take_line,
    input logic [2:0]  take_level,
    input logic [31:0] take_vec,
    input logic [2:0]  cur_level,
    input logic [31:0] line_en,
    input logic [31:0] vec_base,
    input logic [31:0] pending
);
    logic [31:0] en_prev;
    logic [31:0] base_prev;

    // Hold last cycle's enable mask and base for comparison with a take
    always_ff @(posedge clk) begin
        en_prev   <= line_en;
        base_prev <= vec_base;
    end

    AST_TAKE_ABOVE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (take && take_line != 5'(NMI_LINE)) |-> take_level > $past(cur_level)); // R7
    AST_LEVEL_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        (take && take_line != 5'(NMI_LINE)) |-> cur_level == take_level); // R7
    AST_TAKE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (take && take_line != 5'(NMI_LINE)) |-> en_prev[take_line]); // R6
    AST_PARKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (pending & PARK_MASK) == 32'h0); // R4
    AST_NO_PARKED_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> !PARK_MASK[take_line]); // R4
    AST_L1_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (take && take_level == 3'd1) |-> take_vec == base_prev + OFF_L1); // R9
endmodule

bind irq_route_ctrl irq_route_ctrl_chk #(
    .NMI_LINE  (NMI_LINE),
    .PARK_MASK (PARK_MASK),
    .OFF_L1    (OFF_L1)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .take_line  (take_line),
    .take_level (take_level),
    .take_vec   (take_vec),
    .cur_level  (cur_level),
    .line_en    (line_en),
    .vec_base   (vec_base),
    .pending    (pending)
);

// File: tb/irq_route_ctrl_tb_top.sv
`timescale 1ns/1ps
// Directed bench for the interrupt router: one task per scenario.
module irq_route_ctrl_tb_top;
    localparam int NSRC = 6;
    localparam logic [31:0] BASE = 32'h4000_0000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src_raw = '0;
    logic            wr_en = 1'b0;
    logic [7:0]      wr_addr = '0;
    logic [31:0]     wr_data = '0;
    logic [7:0]      rd_addr = '0;
    logic [31:0]     rd_data;
    logic            take;
    logic [4:0]      take_line;
    logic [2:0]      take_level;
    logic [31:0]     take_vec;

    int total = 0;
    int bad   = 0;
    int takes = 0;
    logic [4:0]  last_line;
    logic [2:0]  last_lvl;
    logic [31:0] last_vec;

    irq_route_ctrl #(.NUM_SRC(NSRC)) dut_i (
        .clk (clk), .rst_n (rst_n), .src_raw (src_raw),
        .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
        .rd_addr (rd_addr), .rd_data (rd_data),
        .take (take), .take_line (take_line),
        .take_level (take_level), .take_vec (take_vec)
    );

    always #2.5 clk = ~clk;

    // Record every take strobe away from the active edge
    always @(negedge clk) begin
        if (rst_n && take) begin
            takes++;
            last_line = take_line;
            last_lvl  = take_level;
            last_vec  = take_vec;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    task automatic set_raw(input logic [NSRC-1:0] v);
        @(negedge clk);
        src_raw = v;
    endtask

    // Quiet state between scenarios
    task automatic quiet();
        set_raw('0);
        wr(8'h00, 32'h0);
        wr(8'h05, 32'h0);
        cyc(2);
        wr(8'h01, 32'hFFFF_FFFF);
        wr(8'h02, 32'h0);
        for (int s = 0; s < NSRC; s++) wr(8'h10 + 8'(s), 32'd26);
        cyc(2);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(8'h00, d); chk("R1 enable", d, 32'h0);
        rd(8'h01, d); chk("R1 pending", d, 32'h0);
        rd(8'h02, d); chk("R1 level", d, 32'h0);
        rd(8'h05, d); chk("R1 src enable", d, 32'h0);
        rd(8'h10, d); chk("R1 map0", d, 32'd26);
        chk("R1 take", 32'(take), 32'h0);
    endtask

    task automatic t_src_status();
        logic [31:0] d;
        set_raw(6'b000101);
        wr(8'h05, 32'h1);
        wr(8'h12, 32'd12);
        cyc(1);
        rd(8'h04, d); chk("R2 raw", d, 32'h5);
        rd(8'h06, d); chk("R2 masked", d, 32'h1);
        rd(8'h01, d); chk("R2 unmasked src does not drive line", d, 32'h0);
        quiet();
    endtask

    task automatic t_map();
        logic [31:0] d;
        wr(8'h05, 32'h3);
        set_raw(6'b000001);
        wr(8'h10, 32'd4);
        rd(8'h01, d); chk("R3 map to line 4", d, 32'h10);
        set_raw('0); cyc(1);
        rd(8'h01, d); chk("R5 level line follows low", d, 32'h0);
        wr(8'h10, 32'd6);
        wr(8'h11, 32'd6);
        set_raw(6'b000010); cyc(1);
        rd(8'h01, d); chk("R3 OR merge src1", d, 32'h40);
        set_raw(6'b000001); cyc(1);
        rd(8'h01, d); chk("R3 OR merge src0", d, 32'h40);
        quiet();
    endtask

    task automatic t_parked();
        logic [31:0] d;
        int t0;
        t0 = takes;
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h05, 32'h1);
        wr(8'h10, 32'd28);
        set_raw(6'b000001); cyc(4);
        rd(8'h01, d); chk("R4 parked pending", d, 32'h0);
        chk("R4 parked take", 32'(takes - t0), 32'h0);
        quiet();
    endtask

    task automatic t_edge_mask();
        logic [31:0] d;
        int t0;
        t0 = takes;
        wr(8'h02, 32'h0);
        wr(8'h05, 32'h4);
        wr(8'h12, 32'd9);
        set_raw(6'b000100); cyc(2);
        set_raw('0); cyc(2);
        rd(8'h01, d); chk("R5 edge held", d, 32'h200);
        chk("R6 masked line not taken", 32'(takes - t0), 32'h0);
        wr(8'h00, 32'h200); cyc(3);
        chk("R6 enabled line taken once", 32'(takes - t0), 32'h1);
        chk("R9 high vector", last_vec, BASE + 32'h180);
        chk("R9 level out", 32'(last_lvl), 32'd2);
        rd(8'h02, d); chk("R7 level raised", d, 32'd2);
        wr(8'h01, 32'h200); cyc(1);
        rd(8'h01, d); chk("R5 W1C", d, 32'h0);
        // same priority is held off, higher priority passes
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h05, 32'h18);
        wr(8'h13, 32'd11);
        wr(8'h14, 32'd17);
        t0 = takes;
        set_raw(6'b001000); cyc(4);
        chk("R7 equal level held off", 32'(takes - t0), 32'h0);
        set_raw(6'b011000); cyc(4);
        chk("R7 higher level taken", 32'(takes - t0), 32'h1);
        chk("R7 line 17", 32'(last_line), 32'd17);
        rd(8'h02, d); chk("R7 level now 3", d, 32'd3);
        quiet();
    endtask

    task automatic t_arb();
        int t0;
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h05, 32'h7);
        wr(8'h10, 32'd2);
        wr(8'h11, 32'd8);
        wr(8'h12, 32'd10);
        t0 = takes;
        set_raw(6'b000111); cyc(3);
        chk("R8 one take", 32'(takes - t0), 32'h1);
        chk("R8 tie lowest index", 32'(last_line), 32'd8);
        set_raw(6'b000101);
        wr(8'h02, 32'h0); cyc(2);
        chk("R8 next priority-2 line", 32'(last_line), 32'd10);
        set_raw(6'b000001);
        wr(8'h02, 32'h0); cyc(2);
        chk("R8 level-1 line last", 32'(last_line), 32'd2);
        chk("R9 level-1 vector", last_vec, BASE + 32'h100);
        quiet();
    endtask

    task automatic t_nmi();
        logic [31:0] d;
        int t0;
        wr(8'h02, 32'd5);
        wr(8'h05, 32'h20);
        wr(8'h15, 32'd25);
        t0 = takes;
        set_raw(6'b100000); cyc(4);
        chk("R10 taken with all filters closed", 32'(takes - t0), 32'h1);
        chk("R10 line", 32'(last_line), 32'd25);
        chk("R9 NMI vector", last_vec, BASE + 32'h2C0);
        chk("R9 NMI level", 32'(last_lvl), 32'd7);
        rd(8'h01, d); chk("R10 pending cleared", d, 32'h0);
        rd(8'h02, d); chk("R10 level unchanged", d, 32'd5);
        quiet();
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        #200000;
        bad++; total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        wr(8'h03, BASE);
        t_src_status();
        t_map();
        t_parked();
        t_edge_mask();
        t_arb();
        t_nmi();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule